// File: doc/BRIEF.md
# Multi-function general purpose timer channel

One timer channel built around a single up-counter. A setup register picks one of two clock ticks, a slow one or a fast one, and a power-of-two prescale exponent. The same counter core serves five modes: a plain timer, a PWM generator, a watchdog, a pulse-density modulator and a low-rate blinker for an LED. Two compare values shape the count. The value at `cmp_set` marks the set point. The value at `cmp_top` marks the clear point and the top of the count.

Software writes the setup register, the two compare values, a write-one-to-clear status register and a counter-clear address. A watchdog is kicked by writing the counter-clear address. The setup register can be locked against further writes until reset. The channel index parameter decides whether the channel may request a reset at all.

Top module: `gpt_channel`

## Requirements
- R1: After reset, wave_o, irq_o and rst_req_o are 0, and every register address (0 setup, 1 cmp_set, 2 cmp_top, 3 status, 4 counter) reads 0.
- R2: Setup bit 4 selects the clock: 0 is slow_tick_i and 1 is fast_tick_i. Setup bits [3:0] hold an exponent i. While setup bit 11 (run) is 1, the counter advances once per 2^i selected ticks.
- R3: The counter counts 0 up to cmp_top and returns to 0 on the advance that finds it equal to cmp_top. Any write to address 4 clears the counter, the prescaler, the pulse-density accumulator and the waveform, and it wins over an advance in the same cycle. Address 4 reads the counter.
- R4: Setup bits [7:5] hold the mode: 0 timer, 1 PWM, 2 watchdog, 3 pulse-density, 4 blink. In timer mode wave_o stays 0. In PWM mode wave_o rises after the advance at which count equals cmp_set and falls after the advance at which count equals cmp_top. It is therefore high for (cmp_top-cmp_set)*2^i fast-tick cycles and low for (cmp_set+1)*2^i.
- R5: In PWM mode with cmp_set equal to cmp_top, the clear wins and wave_o stays 0, while both status flags still set.
- R6: In pulse-density mode each advance adds cmp_set to a 16-bit accumulator, and wave_o is the registered carry. Over N advances from a clear, the number of high cycles is N*cmp_set/65536 within one.
- R7: In blink mode wave_o toggles on each return of the counter to 0, so it is high for (cmp_top+1)*2^i cycles at a time.
- R8: In watchdog mode wave_o equals status flag 1. rst_req_o is 1 while status flag 1 and setup bit 10 are both set, but only on a channel whose CHAN_IDX is below RST_CHANS (6). On any other channel it is 0.
- R9: Status bit 0 sets on a cmp_set match and bit 1 on a cmp_top match. Both are sticky, a 1 written to a bit clears it, and a set wins over a clear in the same cycle. irq_o = (bit0 & setup bit 8) | (bit1 & setup bit 9).
- R10: Once setup bit 15 (lock) is 1, writes to the setup register are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | Slow clock enable |
| fast_tick_i | input | 1 | Fast clock enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data, combinational from the address |
| wave_o | output | 1 | Waveform output |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Reset request |

## Verification
The set point and the clear point can fall on the same advance when cmp_set equals cmp_top. The bench provokes this in PWM mode with equal compare values. It samples wave_o on every cycle across several periods and expects it never to rise, and it expects both status flags to read back as set. In watchdog mode, counter clears repeated before the top is reached must keep rst_req_o low. Letting the top be reached must raise it on the low-index instance, but never on the high-index instance.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [2:0] {
    MODE_TIMER = 3'd0,
    MODE_PWM   = 3'd1,
    MODE_WDOG  = 3'd2,
    MODE_PDM   = 3'd3,
    MODE_BLINK = 3'd4
  } gpt_mode_e;

  localparam int B_CLKSEL = 4;
  localparam int B_MODE   = 5;
  localparam int B_IEN0   = 8;
  localparam int B_IEN1   = 9;
  localparam int B_RSTEN  = 10;
  localparam int B_RUN    = 11;
  localparam int B_LOCK   = 15;

  localparam int A_SETUP  = 0;
  localparam int A_CSET   = 1;
  localparam int A_CTOP   = 2;
  localparam int A_STAT   = 3;
  localparam int A_COUNT  = 4;
endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale #(
  parameter int EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             div_o
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [PRE_W-1:0] pre_q, mask;

  always_comb mask = (PRE_W'(1) << exp_i) - PRE_W'(1);
  assign div_o = tick_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_i) pre_q <= pre_q + PRE_W'(1);
  end

  p_div_needs_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> tick_i);
  p_pre_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] set_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ev_set_o,
  output logic             ev_top_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign ev_set_o = tick_i && (cnt_q == set_i);
  assign ev_top_o = tick_i && (cnt_q == top_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= ev_top_o ? '0 : cnt_q + CNT_W'(1);
  end

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == top_i) |=> cnt_q == '0);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/gpt_wave.sv
module gpt_wave
  import gpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  gpt_mode_e        mode_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             ev_set_i,
  input  logic             ev_top_i,
  input  logic [CNT_W-1:0] step_i,
  output logic             wave_o
);
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W:0]   acc_sum;
  logic             wave_q;

  assign acc_sum = {1'b0, acc_q} + {1'b0, step_i};
  assign wave_o  = wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      wave_q <= 1'b0;
    end else if (clr_i) begin
      acc_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      unique case (mode_i)
        MODE_PWM: begin
          if (ev_top_i)      wave_q <= 1'b0;  // clear beats set
          else if (ev_set_i) wave_q <= 1'b1;
        end
        MODE_PDM: begin
          if (tick_i) begin
            acc_q  <= acc_sum[CNT_W-1:0];
            wave_q <= acc_sum[CNT_W];
          end
        end
        MODE_BLINK: if (ev_top_i) wave_q <= ~wave_q;
        default: wave_q <= 1'b0;
      endcase
    end
  end

  p_clear_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PWM && ev_top_i) |=> !wave_o);
  p_blink_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BLINK && ev_top_i && !clr_i) |=> wave_o != $past(wave_o));
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int EXP_W     = 4,
  parameter int ADDR_W    = 3,
  parameter int CHAN_IDX  = 0,
  parameter int RST_CHANS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              fast_tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              wave_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam bit RST_OK = (CHAN_IDX < RST_CHANS);

  logic [CNT_W-1:0] setup_q, cset_q, ctop_q, cnt;
  logic [1:0]       flag_q, flag_clr;
  logic             wr_setup, wr_cset, wr_ctop, wr_stat, wr_cnt;
  logic             run, sel_tick, adv, ev_set, ev_top, gen_wave;
  gpt_mode_e        mode;

  assign wr_setup = reg_we_i && reg_addr_i == ADDR_W'(A_SETUP) && !setup_q[B_LOCK];
  assign wr_cset  = reg_we_i && reg_addr_i == ADDR_W'(A_CSET);
  assign wr_ctop  = reg_we_i && reg_addr_i == ADDR_W'(A_CTOP);
  assign wr_stat  = reg_we_i && reg_addr_i == ADDR_W'(A_STAT);
  assign wr_cnt   = reg_we_i && reg_addr_i == ADDR_W'(A_COUNT);
  assign flag_clr = wr_stat ? reg_wdata_i[1:0] : 2'b00;

  assign mode     = gpt_mode_e'(setup_q[B_MODE +: 3]);
  assign run      = setup_q[B_RUN];
  assign sel_tick = run && (setup_q[B_CLKSEL] ? fast_tick_i : slow_tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q <= '0;
      cset_q  <= '0;
      ctop_q  <= '0;
      flag_q  <= '0;
    end else begin
      if (wr_setup) setup_q <= reg_wdata_i;
      if (wr_cset)  cset_q  <= reg_wdata_i;
      if (wr_ctop)  ctop_q  <= reg_wdata_i;
      flag_q <= (flag_q & ~flag_clr) | {ev_top, ev_set};  // set wins
    end
  end

  gpt_prescale #(.EXP_W(EXP_W)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(sel_tick), .clr_i(wr_cnt),
    .exp_i (setup_q[EXP_W-1:0]), .div_o(adv)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i), .rst_ni(rst_ni), .tick_i(adv), .clr_i(wr_cnt),
    .set_i   (cset_q), .top_i(ctop_q), .cnt_o(cnt),
    .ev_set_o(ev_set), .ev_top_o(ev_top)
  );

  gpt_wave #(.CNT_W(CNT_W)) u_wave (
    .clk_i   (clk_i), .rst_ni(rst_ni), .mode_i(mode), .clr_i(wr_cnt),
    .tick_i  (adv), .ev_set_i(ev_set), .ev_top_i(ev_top),
    .step_i  (cset_q), .wave_o(gen_wave)
  );

  assign wave_o = (mode == MODE_WDOG) ? flag_q[1] : gen_wave;
  assign irq_o  = (flag_q[0] & setup_q[B_IEN0]) | (flag_q[1] & setup_q[B_IEN1]);

  generate
    if (RST_OK) begin : g_rst
      assign rst_req_o = (mode == MODE_WDOG) && flag_q[1] && setup_q[B_RSTEN];
    end else begin : g_no_rst
      assign rst_req_o = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (int'(reg_addr_i))
      A_SETUP: reg_rdata_o = setup_q;
      A_CSET:  reg_rdata_o = cset_q;
      A_CTOP:  reg_rdata_o = ctop_q;
      A_STAT:  reg_rdata_o = CNT_W'(flag_q);
      A_COUNT: reg_rdata_o = cnt;
      default: reg_rdata_o = '0;
    endcase
  end

  p_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_q[B_LOCK] && reg_we_i && reg_addr_i == ADDR_W'(A_SETUP)) |=> $stable(setup_q));
  p_flag0_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[0] && !(wr_stat && reg_wdata_i[0])) |=> flag_q[0]);
  p_flag1_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[1] && !(wr_stat && reg_wdata_i[1])) |=> flag_q[1]);
  p_rst_follows_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (wave_o && setup_q[B_RSTEN]));
endmodule

// File: tb/gpt_channel_test.sv
module gpt_channel_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slow_tick_i, fast_tick_i;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o, rdata_hi;
  logic        wave_o, irq_o, rst_req_o, wave_hi, irq_hi, rst_hi;

  int checks = 0, failures = 0;
  logic [1:0] slow_div = '0;

  always #2 clk_i = ~clk_i;

  assign fast_tick_i = 1'b1;
  assign slow_tick_i = (slow_div == 2'd3);
  always_ff @(posedge clk_i) slow_div <= slow_div + 2'd1;

  gpt_channel #(.CHAN_IDX(0)) uut (
    .clk_i, .rst_ni, .slow_tick_i, .fast_tick_i, .reg_we_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .wave_o, .irq_o, .rst_req_o
  );

  gpt_channel #(.CHAN_IDX(6)) uut_hi (
    .clk_i, .rst_ni, .slow_tick_i, .fast_tick_i, .reg_we_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o(rdata_hi), .wave_o(wave_hi), .irq_o(irq_hi),
    .rst_req_o(rst_hi)
  );

  localparam logic [15:0] FAST = 16'h0010, RUN = 16'h0800, IE0 = 16'h0100,
                          IE1 = 16'h0200, RSTE = 16'h0400, LOCK = 16'h8000;

  function automatic logic [15:0] mode_bits(int m);
    return 16'(m) << 5;
  endfunction
  function automatic int pwm_high(int s, int t, int i);
    return (t - s) << i;
  endfunction
  function automatic int pwm_low(int s, int i);
    return (s + 1) << i;
  endfunction
  function automatic int pdm_ones(int n, int k);
    return (n * k) / 65536;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 3'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    reg_addr_i = 3'(a);
    #1 d = reg_rdata_o;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wait_level(input logic lvl, input int limit, output bit ok);
    ok = 1'b0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk_i);
      if (wave_o == lvl) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_len(input logic lvl, input int limit, output int n);
    n = 0;
    while (wave_o == lvl && n < limit) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [15:0] d, d2;
    int n, hi, lo;
    bit ok;
    void'($urandom(32'd20240607));
    do_reset();

    // R1 reset state
    @(negedge clk_i);
    chk(!wave_o && !irq_o && !rst_req_o, "R1 outputs", {wave_o, irq_o, rst_req_o}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      chk(d == 0, "R1 register", d, 0);
    end

    // R2/R3 prescaled counting on fast tick
    for (int it = 0; it < 4; it++) begin
      int e = (it == 3) ? 0 : int'($urandom_range(1, 4));
      n = int'($urandom_range(40, 300));
      wr(0, FAST | RUN | 16'(e));
      wr(2, 16'hFFFF);
      wr(4, 16'h0);
      repeat (n) @(posedge clk_i);
      @(negedge clk_i);
      rd(4, d);
      chk(int'(d) == (n >> e), "R2 prescaled count", d, n >> e);
    end

    // R2 slow tick select
    wr(0, RUN | 16'd1);
    wr(4, 16'h0);
    repeat (64) @(posedge clk_i);
    @(negedge clk_i);
    rd(4, d);
    chk(d >= 7 && d <= 9, "R2 slow clock", d, 8);

    // R3 wrap at top
    wr(0, FAST | RUN);
    wr(2, 16'd9);
    wr(4, 16'h0);
    repeat (23) @(posedge clk_i);
    @(negedge clk_i);
    rd(4, d);
    chk(d == 16'd3, "R3 wrap", d, 3);

    // R4 PWM duty and period
    for (int it = 0; it < 5; it++) begin
      int e = int'($urandom_range(0, 2));
      int t = int'($urandom_range(4, 40));
      int s = int'($urandom_range(0, t - 1));
      wr(0, FAST | RUN | mode_bits(1) | 16'(e));
      wr(1, 16'(s));
      wr(2, 16'(t));
      wr(4, 16'h0);
      wait_level(1'b1, 2000, ok);
      run_len(1'b1, 2000, hi);
      run_len(1'b0, 2000, lo);
      chk(ok && hi == pwm_high(s, t, e), "R4 pwm high", hi, pwm_high(s, t, e));
      chk(lo == pwm_low(s, e), "R4 pwm low", lo, pwm_low(s, e));
    end

    // R5 coincident set and clear
    wr(0, FAST | RUN | mode_bits(1));
    wr(1, 16'd7);
    wr(2, 16'd7);
    wr(3, 16'h3);
    wr(4, 16'h0);
    n = 0;
    repeat (40) begin
      @(negedge clk_i);
      if (wave_o) n++;
    end
    chk(n == 0, "R5 clear wins", n, 0);
    rd(3, d);
    chk(d == 16'h3, "R5 both flags", d, 3);

    // R6 pulse density
    for (int it = 0; it < 2; it++) begin
      int k = int'($urandom_range(1000, 60000));
      int exp_n = pdm_ones(4096, k);
      wr(0, FAST | RUN | mode_bits(3));
      wr(1, 16'(k));
      wr(2, 16'hFFFF);
      wr(4, 16'h0);
      n = 0;
      repeat (4096) begin
        @(negedge clk_i);
        if (wave_o) n++;
      end
      chk(n >= exp_n - 1 && n <= exp_n + 1, "R6 density", n, exp_n);
    end

    // R7 blink
    wr(0, FAST | RUN | mode_bits(4) | 16'd1);
    wr(2, 16'd12);
    wr(4, 16'h0);
    wait_level(1'b1, 2000, ok);
    run_len(1'b1, 2000, hi);
    run_len(1'b0, 2000, lo);
    chk(ok && hi == 26, "R7 blink high", hi, 26);
    chk(lo == 26, "R7 blink low", lo, 26);

    // R8 watchdog
    wr(0, FAST | RUN | mode_bits(2) | RSTE | IE1);
    wr(1, 16'hFFFF);
    wr(2, 16'd20);
    wr(4, 16'h0);
    wr(3, 16'h3);
    n = 0;
    repeat (6) begin
      repeat (10) @(negedge clk_i);
      if (rst_req_o || wave_o) n++;
      wr(4, 16'h0);
    end
    chk(n == 0, "R8 kicked watchdog quiet", n, 0);
    repeat (30) @(negedge clk_i);
    chk(rst_req_o && wave_o && irq_o, "R8 expiry", {rst_req_o, wave_o, irq_o}, 7);
    chk(!rst_hi && wave_hi, "R8 high index no reset", {rst_hi, wave_hi}, 1);
    wr(0, mode_bits(2) | RSTE | IE1);
    wr(3, 16'h2);
    chk(!rst_req_o && !wave_o && !irq_o, "R8 flag clear", {rst_req_o, wave_o, irq_o}, 0);

    // R9 flags, w1c, irq enables; timer mode output low
    wr(0, FAST | RUN | IE0);
    wr(1, 16'd5);
    wr(2, 16'd9);
    wr(4, 16'h0);
    wr(3, 16'h3);
    n = 0;
    repeat (20) begin
      @(negedge clk_i);
      if (wave_o) n++;
    end
    chk(n == 0, "R9 timer wave low", n, 0);
    rd(3, d);
    chk(d == 16'h3 && irq_o, "R9 flags set", {d[1:0], irq_o}, 7);
    wr(0, IE0);
    wr(3, 16'h1);
    rd(3, d);
    chk(d == 16'h2 && !irq_o, "R9 w1c and enable gating", {d[1:0], irq_o}, 4);

    // R10 lock
    wr(0, FAST | RUN | LOCK);
    wr(2, 16'hFFFF);
    wr(0, 16'h0);
    rd(0, d);
    chk(d == (FAST | RUN | LOCK), "R10 setup locked", d, FAST | RUN | LOCK);
    rd(4, d);
    repeat (5) @(negedge clk_i);
    rd(4, d2);
    chk(d2 == d + 16'd5, "R10 still running", d2, d + 16'd5);
    do_reset();
    @(negedge clk_i);
    rd(0, d);
    chk(d == 0, "R10 unlock by reset", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule